// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns the program counter of an instruction fetch on a 64-bit processor into a physical address, or into a single fault code. Each request falls into one of several translation paths, chosen from the PC and the current privilege mode:

- A privileged-firmware bypass, selected by the low PC bit.
- A direct physical mode, selected by a flag.
- A kernel-only direct-mapped window in the upper virtual space.
- An ordinary page lookup through an external translation buffer.

The block presents the page number and address-space number to the external buffer on a combinational lookup port. The buffer answers in the same cycle with a hit flag, a physical page number and a per-mode read-enable mask. The block then checks the resulting physical address against the implemented physical width and the uncached I/O region.

The result is registered. It appears one clock after the request, together with a response-valid strobe. Only the first detected problem is reported. The block holds no translation storage and takes no action on a fault.

Top module: `ifetch_xlate`

## Requirements
- R1: While reset is high, and on the first cycle after it, `rsp_vld`, `rsp_pa`, `rsp_unc` and `rsp_fault` are all zero.
- R2: When PC bit 0 is 1, the physical address is the PC with bits 1:0 cleared, masked to PA_IMPL bits. No lookup is requested (`tlb_req` stays 0). The request takes this path whatever `req_phys` and `req_mode` are.
- R3: When PC bit 0 is 0 and `req_phys` is 1, the physical address is the full PC unchanged, with no lookup.
- R4: On the remaining requests, if PC bits 63 down to VA_IMPL-1 (63:42 by default) are not all equal, the fault is access violation (code 1) and `rsp_pa` is zero. This check comes before the window test.
- R5: On a well-formed PC with bits 47:41 equal to 7'h7E, any mode other than kernel (`req_mode` 0) gives access violation (code 1) with `rsp_pa` zero.
- R6: In kernel mode, that window maps the PC masked to PA_IMPL bits. If the result has bit 40 set, bits 43:40 are forced to 1. Otherwise every bit from 40 upward is cleared.
- R7: All other fetches assert `tlb_req`, with `tlb_vpn` = PC[VA_IMPL-1:PAGE_SHIFT] and `tlb_asn` = `req_asn`. On a permitted hit, the physical address is `tlb_ppn` shifted left by PAGE_SHIFT, ORed with the page offset with bits 1:0 cleared.
- R8: A lookup miss gives fetch-miss (code 2). A hit whose `tlb_xre` bit at index `req_mode` is 0 gives access violation (code 1). In both cases `rsp_pa` is zero.
- R9: If a formed physical address has any bit at or above PA_IMPL set, the fault is bad physical address (code 3).
- R10: If a formed physical address with no earlier fault has bit 43 set, one of two cases applies. If bits 42:35 are all ones, the fault is unimplemented register space (code 4). Otherwise `rsp_unc` is 1, bits 42:35 of `rsp_pa` are cleared, and the fault is uncached fetch (code 5).
- R11: A response appears exactly one cycle after each `req_vld` cycle. In a cycle with no response, `rsp_fault`, `rsp_unc` and `rsp_pa` are zero.
- R12: Fault codes are 3 bits: 0 none, 1 access violation, 2 fetch miss, 3 bad physical address, 4 unimplemented register space, 5 uncached fetch. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Fetch request valid |
| req_pc | input | 64 | Fetch virtual address |
| req_phys | input | 1 | Treat the address as physical |
| req_mode | input | 2 | Current mode: 0 kernel, 1 executive, 2 supervisor, 3 user |
| req_asn | input | ASN_W | Address-space number |
| tlb_req | output | 1 | Lookup requested this cycle |
| tlb_vpn | output | VA_IMPL-PAGE_SHIFT | Virtual page number to look up |
| tlb_asn | output | ASN_W | Address-space number to match |
| tlb_hit | input | 1 | Lookup hit |
| tlb_ppn | input | PPN_W | Physical page number of the hit |
| tlb_xre | input | 4 | Read-enable per mode, bit index = mode |
| rsp_vld | output | 1 | Result valid |
| rsp_pa | output | PA_IMPL | Physical address |
| rsp_unc | output | 1 | Access is uncacheable and strictly ordered |
| rsp_fault | output | 3 | Fault code |

## Verification
The hardest case to reach is a fault raised only by the physical-address screen after a legal translation. Examples are an uncached fetch or a register-space hit through the kernel window, where sign extension on bit 40 sets bit 43, and a bad address from an oversized page number on a permitted hit. The bench reaches these by crossing a set of chosen PC values with every mode, both physical-flag settings, both hit values, four read-enable patterns and three page numbers, one of which reaches bit 43 and one bit 44. The expected result for each combination is computed arithmetically from the requirements.

// File: rtl/ifetch_xlate_pkg.sv
package ifetch_xlate_pkg;

    localparam int XLEN = 64;

    // direct-mapped kernel window: selector field and its tag
    localparam int        WIN_HI   = 47;
    localparam int        WIN_LO   = 41;
    localparam logic [6:0] WIN_TAG = 7'h7E;
    localparam int        WIN_SIGN = 40;

    // uncached region marker and the field cleared on such an access
    localparam int UNC_BIT = 43;
    localparam int UNC_FHI = 42;
    localparam int UNC_FLO = 35;

    typedef enum logic [1:0] {
        MODE_KERNEL = 2'd0,
        MODE_EXEC   = 2'd1,
        MODE_SUPER  = 2'd2,
        MODE_USER   = 2'd3
    } priv_e;

    typedef enum logic [2:0] {
        FLT_NONE      = 3'd0,
        FLT_ACV       = 3'd1,
        FLT_MISS      = 3'd2,
        FLT_BAD_PA    = 3'd3,
        FLT_REG_SPACE = 3'd4,
        FLT_UNC_FETCH = 3'd5
    } fault_e;

    typedef enum logic [2:0] {
        RT_FIRMWARE,
        RT_PHYS,
        RT_MALFORMED,
        RT_WINDOW,
        RT_WINDOW_DENY,
        RT_LOOKUP
    } route_e;

    typedef struct packed {
        logic [XLEN-1:0] pa;
        fault_e          flt;
    } stage_t;

    // true when every bit of the slice above the implemented width agrees
    function automatic logic all_same(input logic [XLEN-1:0] v, input int lo);
        logic ones;
        logic zeros;
        ones  = 1'b1;
        zeros = 1'b1;
        for (int i = 0; i < XLEN; i++) begin
            if (i >= lo) begin
                ones  = ones & v[i];
                zeros = zeros & ~v[i];
            end
        end
        return ones | zeros;
    endfunction

endpackage

// File: rtl/ifetch_route.sv
module ifetch_route
    import ifetch_xlate_pkg::*;
#(
    parameter int VA_IMPL = 43
) (
    input  logic [XLEN-1:WIN_LO] pc_hi,
    input  logic                 pc_fw,
    input  logic                 phys,
    input  priv_e                mode,
    output route_e               route
);
    logic [XLEN-1:0] hi_ext;
    logic            well_formed;
    logic            in_window;

    always_comb begin
        hi_ext               = '0;
        hi_ext[XLEN-1:WIN_LO] = pc_hi;
    end

    assign well_formed = all_same(hi_ext, VA_IMPL - 1);
    assign in_window   = (pc_hi[WIN_HI:WIN_LO] == WIN_TAG);

    // priority: firmware bypass, physical flag, form check, window, lookup
    always_comb begin
        if (pc_fw)
            route = RT_FIRMWARE;
        else if (phys)
            route = RT_PHYS;
        else if (!well_formed)
            route = RT_MALFORMED;
        else if (in_window)
            route = (mode == MODE_KERNEL) ? RT_WINDOW : RT_WINDOW_DENY;
        else
            route = RT_LOOKUP;
    end

endmodule

// File: rtl/ifetch_pa_form.sv
module ifetch_pa_form
    import ifetch_xlate_pkg::*;
#(
    parameter int PA_IMPL    = 44,
    parameter int PAGE_SHIFT = 13,
    parameter int PPN_W      = 32
) (
    input  route_e           route,
    input  logic [XLEN-1:0]  pc,
    input  priv_e            mode,
    input  logic             hit,
    input  logic [PPN_W-1:0] ppn,
    input  logic [3:0]       xre,
    output stage_t           res
);
    localparam logic [XLEN-1:0] PA_MASK = {{(XLEN-PA_IMPL){1'b0}}, {PA_IMPL{1'b1}}};

    logic [XLEN-1:0] page_base;
    logic [XLEN-1:0] page_off;
    logic [XLEN-1:0] win_pa;

    assign page_base = XLEN'(ppn) << PAGE_SHIFT;

    always_comb begin
        page_off                   = '0;
        page_off[PAGE_SHIFT-1:2]   = pc[PAGE_SHIFT-1:2];
    end

    always_comb begin
        win_pa = pc & PA_MASK;
        if (win_pa[WIN_SIGN])
            win_pa[UNC_BIT:WIN_SIGN] = '1;
        else
            win_pa[XLEN-1:WIN_SIGN] = '0;
    end

    always_comb begin
        res.pa  = '0;
        res.flt = FLT_NONE;
        unique case (route)
            RT_FIRMWARE:    res.pa = {pc[XLEN-1:2], 2'b00} & PA_MASK;
            RT_PHYS:        res.pa = pc;
            RT_MALFORMED:   res.flt = FLT_ACV;
            RT_WINDOW_DENY: res.flt = FLT_ACV;
            RT_WINDOW:      res.pa = win_pa;
            RT_LOOKUP: begin
                if (!hit)
                    res.flt = FLT_MISS;
                else if (!xre[mode])
                    res.flt = FLT_ACV;
                else
                    res.pa = page_base | page_off;
            end
            default:        res.flt = FLT_ACV;
        endcase
    end

endmodule

// File: rtl/ifetch_pa_screen.sv
module ifetch_pa_screen
    import ifetch_xlate_pkg::*;
#(
    parameter int PA_IMPL = 44
) (
    input  stage_t              in,
    output logic [PA_IMPL-1:0]  pa,
    output logic                unc,
    output fault_e              flt
);
    logic over_width;
    logic reg_space;

    assign over_width = |in.pa[XLEN-1:PA_IMPL];
    assign reg_space  = &in.pa[UNC_FHI:UNC_FLO];

    always_comb begin
        pa  = in.pa[PA_IMPL-1:0];
        unc = 1'b0;
        flt = in.flt;
        if (in.flt == FLT_NONE) begin
            if (over_width) begin
                flt = FLT_BAD_PA;
            end else if (in.pa[UNC_BIT]) begin
                if (reg_space) begin
                    flt = FLT_REG_SPACE;
                end else begin
                    unc                = 1'b1;
                    pa[UNC_FHI:UNC_FLO] = '0;
                    flt                = FLT_UNC_FETCH;
                end
            end
        end
    end

endmodule

// File: rtl/ifetch_xlate.sv
module ifetch_xlate
    import ifetch_xlate_pkg::*;
#(
    parameter int VA_IMPL    = 43,
    parameter int PA_IMPL    = 44,
    parameter int PAGE_SHIFT = 13,
    parameter int ASN_W      = 8,
    parameter int PPN_W      = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_vld,
    input  logic [63:0]                   req_pc,
    input  logic                          req_phys,
    input  logic [1:0]                    req_mode,
    input  logic [ASN_W-1:0]              req_asn,
    output logic                          tlb_req,
    output logic [VA_IMPL-PAGE_SHIFT-1:0] tlb_vpn,
    output logic [ASN_W-1:0]              tlb_asn,
    input  logic                          tlb_hit,
    input  logic [PPN_W-1:0]              tlb_ppn,
    input  logic [3:0]                    tlb_xre,
    output logic                          rsp_vld,
    output logic [PA_IMPL-1:0]            rsp_pa,
    output logic                          rsp_unc,
    output logic [2:0]                    rsp_fault
);
    route_e              route;
    stage_t              formed;
    logic [PA_IMPL-1:0]  scr_pa;
    logic                scr_unc;
    fault_e              scr_flt;
    priv_e               mode;

    assign mode = priv_e'(req_mode);

    ifetch_route #(.VA_IMPL(VA_IMPL)) route_i (
        .pc_hi (req_pc[XLEN-1:WIN_LO]),
        .pc_fw (req_pc[0]),
        .phys  (req_phys),
        .mode  (mode),
        .route (route)
    );

    ifetch_pa_form #(
        .PA_IMPL   (PA_IMPL),
        .PAGE_SHIFT(PAGE_SHIFT),
        .PPN_W     (PPN_W)
    ) form_i (
        .route (route),
        .pc    (req_pc),
        .mode  (mode),
        .hit   (tlb_hit),
        .ppn   (tlb_ppn),
        .xre   (tlb_xre),
        .res   (formed)
    );

    ifetch_pa_screen #(.PA_IMPL(PA_IMPL)) screen_i (
        .in  (formed),
        .pa  (scr_pa),
        .unc (scr_unc),
        .flt (scr_flt)
    );

    assign tlb_req = req_vld && (route == RT_LOOKUP);
    assign tlb_vpn = req_pc[VA_IMPL-1:PAGE_SHIFT];
    assign tlb_asn = req_asn;

    always_ff @(posedge clk) begin
        if (rst || !req_vld) begin
            rsp_vld   <= 1'b0;
            rsp_pa    <= '0;
            rsp_unc   <= 1'b0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_vld   <= 1'b1;
            rsp_pa    <= scr_pa;
            rsp_unc   <= scr_unc;
            rsp_fault <= scr_flt;
        end
    end

    AST_FW_NO_LOOKUP: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_pc[0]) |-> !tlb_req);                                   // R2
    AST_MISS_HAD_LOOKUP: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_fault == FLT_MISS) |-> $past(tlb_req));                 // R8
    AST_DENIED_PA_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && (rsp_fault == FLT_ACV || rsp_fault == FLT_MISS)) |-> (rsp_pa == '0)); // R8
    AST_UNC_IS_FETCH_FAULT: assert property (@(posedge clk) disable iff (rst)
        rsp_unc |-> (rsp_fault == FLT_UNC_FETCH && rsp_pa[UNC_FHI:UNC_FLO] == '0)); // R10
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        rsp_vld |-> $past(req_vld));                                            // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_vld |-> (rsp_fault == 3'd0 && !rsp_unc && rsp_pa == '0));         // R11
    AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        rsp_vld |-> (rsp_fault <= 3'd5));                                       // R12

endmodule

// File: tb/ifetch_xlate_tb_top.sv
`timescale 1ns/1ps
module ifetch_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_vld;
    logic [63:0] req_pc;
    logic        req_phys;
    logic [1:0]  req_mode;
    logic [7:0]  req_asn;
    logic        tlb_req;
    logic [29:0] tlb_vpn;
    logic [7:0]  tlb_asn;
    logic        tlb_hit;
    logic [31:0] tlb_ppn;
    logic [3:0]  tlb_xre;
    logic        rsp_vld;
    logic [43:0] rsp_pa;
    logic        rsp_unc;
    logic [2:0]  rsp_fault;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    ifetch_xlate dut_i (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_pc(req_pc),
        .req_phys(req_phys), .req_mode(req_mode), .req_asn(req_asn),
        .tlb_req(tlb_req), .tlb_vpn(tlb_vpn), .tlb_asn(tlb_asn),
        .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_xre(tlb_xre),
        .rsp_vld(rsp_vld), .rsp_pa(rsp_pa), .rsp_unc(rsp_unc), .rsp_fault(rsp_fault)
    );

    logic [63:0] vecs [13];
    logic [31:0] ppns [3];
    logic [3:0]  xres [4];

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // expected result computed from the requirements
    task automatic model(input logic [63:0] pc, input bit phys, input int mode,
                         input bit hit, input logic [31:0] ppn, input logic [3:0] xre,
                         output logic [63:0] pa, output bit unc, output int flt,
                         output bit look, output string tag);
        logic [63:0] m44 = (64'd1 << 44) - 64'd1;
        pa = 0; unc = 0; flt = 0; look = 0; tag = "R7";
        if (pc[0]) begin
            pa = (pc & ~64'd3) & m44; tag = "R2";
        end else if (phys) begin
            pa = pc; tag = "R3";
        end else if (!(pc[63:42] == '0 || pc[63:42] == '1)) begin
            flt = 1; tag = "R4";
        end else if (pc[47:41] == 7'h7E) begin
            if (mode != 0) begin
                flt = 1; tag = "R5";
            end else begin
                pa = pc & m44;
                if (pa[40]) pa = pa | 64'h0000_0F00_0000_0000;
                else        pa = pa % (64'd1 << 40);
                tag = "R6";
            end
        end else begin
            look = 1;
            if (!hit) begin
                flt = 2; tag = "R8";
            end else if (!xre[mode]) begin
                flt = 1; tag = "R8";
            end else begin
                pa = 64'(ppn) * 64'd8192 + ((pc % 64'd8192) & ~64'd3);
            end
        end
        if (flt == 0) begin
            if (pa >= (64'd1 << 44)) begin
                flt = 3; tag = "R9";
            end else if (pa[43]) begin
                tag = "R10";
                if (pa[42:35] == 8'hFF) flt = 4;
                else begin
                    unc = 1; flt = 5;
                    pa = pa & ~(64'hFF << 35);
                end
            end
        end
    endtask

    initial begin
        vecs[0]  = 64'h0000_0000_1234_5678;  // ordinary lookup
        vecs[1]  = 64'h0000_0000_0000_4001;  // firmware bypass
        vecs[2]  = 64'hFFFF_F800_0000_1003;  // firmware, uncached after mask
        vecs[3]  = 64'h0000_0FFF_F800_0001;  // firmware, register space
        vecs[4]  = 64'h0000_0400_0000_0000;  // malformed upper bits
        vecs[5]  = 64'hFFFF_FC00_0012_3450;  // window, bit 40 clear
        vecs[6]  = 64'hFFFF_FD00_0000_2000;  // window, bit 40 set -> uncached
        vecs[7]  = 64'hFFFF_FDFF_8000_0000;  // window, register space
        vecs[8]  = 64'h7FFF_FC00_0000_0000;  // window tag but malformed
        vecs[9]  = 64'hFFFF_F800_0000_0abc;  // negative, outside window
        vecs[10] = 64'h0001_0000_0000_0000;  // physical: beyond width
        vecs[11] = 64'h0000_0800_0000_0100;  // physical: uncached
        vecs[12] = 64'h0000_0000_0000_2007;  // firmware, bit 1 set
        ppns[0] = 32'h0000_1234;
        ppns[1] = 32'h4000_0000;             // reaches bit 43
        ppns[2] = 32'h8000_0001;             // reaches bit 44
        xres[0] = 4'h0; xres[1] = 4'hF; xres[2] = 4'h5; xres[3] = 4'hA;

        rst = 1; req_vld = 0; req_pc = 0; req_phys = 0; req_mode = 0; req_asn = 0;
        tlb_hit = 0; tlb_ppn = 0; tlb_xre = 0;
        repeat (3) @(negedge clk);
        check(rsp_vld == 0 && rsp_pa == 0 && rsp_unc == 0 && rsp_fault == 0, "R1 reset",
              {rsp_vld, rsp_unc, rsp_fault, rsp_pa}, 64'd0);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(rsp_vld == 0 && rsp_fault == 0, "R1 after reset", {rsp_vld, rsp_fault}, 64'd0);

        for (int m = 0; m < 4; m++)
        for (int v = 0; v < 13; v++)
        for (int ph = 0; ph < 2; ph++)
        for (int h = 0; h < 2; h++)
        for (int x = 0; x < 4; x++)
        for (int p = 0; p < 3; p++) begin
            logic [63:0] epa;
            bit eunc, elook;
            int eflt;
            string tag;
            req_vld = 1; req_pc = vecs[v]; req_phys = ph[0]; req_mode = m[1:0];
            req_asn = 8'(v * 17 + m); tlb_hit = h[0]; tlb_ppn = ppns[p]; tlb_xre = xres[x];
            model(vecs[v], ph[0], m, h[0], ppns[p], xres[x], epa, eunc, eflt, elook, tag);
            #1;
            check(tlb_req == elook, {tag, " lookup request"}, 64'(tlb_req), 64'(elook));
            if (elook)
                check(tlb_vpn == vecs[v][42:13] && tlb_asn == req_asn, "R7 lookup fields",
                      {tlb_asn, 26'd0, tlb_vpn}, {req_asn, 26'd0, vecs[v][42:13]});
            @(negedge clk);
            check(rsp_vld == 1, "R11 response valid", 64'(rsp_vld), 64'd1);
            check(int'(rsp_fault) == eflt, {tag, " fault"}, 64'(rsp_fault), 64'(eflt));
            check(rsp_pa == epa[43:0], {tag, " pa"}, 64'(rsp_pa), 64'(epa[43:0]));
            check(rsp_unc == eunc, {tag, " uncached"}, 64'(rsp_unc), 64'(eunc));
            check(rsp_fault <= 3'd5, "R12 code range", 64'(rsp_fault), 64'd5);
        end

        // a request that leaves no trace once req_vld drops
        req_vld = 1; req_pc = vecs[6]; req_mode = 0; req_phys = 0;
        @(negedge clk);
        req_vld = 0;
        @(negedge clk);
        check(rsp_vld == 0 && rsp_unc == 0 && rsp_fault == 0 && rsp_pa == 0, "R11 idle",
              {rsp_vld, rsp_unc, rsp_fault, rsp_pa}, 64'd0);

        done = 1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            report();
        end
    end

endmodule